// File: doc/BRIEF.md
# NAND Ready/Busy Wait and Read Strobe Sequencer

This block runs the slow part of a NAND flash transaction once a command has gone out on the bus. It takes a one-cycle command pulse with a 3-bit type code. Command types that involve a long device operation make it hold off for a guard interval. After that it watches the device's active-low ready/busy line until ready has been seen cleanly. Read types then pulse the active-low read-enable line once per byte and capture each byte from the data bus.

The guard interval scales with a 4-bit cycle field and with a relaxed-timing flag. The same cycle field also sets how long read-enable stays low for each byte. The cycle field, the timing flag and the read length are all taken at the moment the command is accepted. A single-clock done pulse marks the end of every command, and a busy output covers the whole time in between. Command pulses that arrive while busy are dropped.

Top module: `nand_rb_sequencer`

## Requirements
- R1: Command type encoding: 1 and 2 are write-then-wait types, 3 and 4 are read-after-wait types, 5 reads without waiting, and 0, 6 and 7 finish at once. For these last three, done is high in the first cycle after the accepting edge and busy never rises.
- R2: For the wait types, the guard length is D = 8*(2+cyc) clocks when relaxed timing is 0 and D = 16*(2+cyc) clocks when it is 1. The ready/busy input is not sampled during the guard. The first sample is taken at edge D+1 after the accepting edge, so the wait ends no earlier than edge D+2.
- R3: If the ready/busy line is already high when the guard ends, the device is treated as ready and the wait ends at edge D+2.
- R4: The wait ends only at an edge where the line samples high and also sampled high at the previous post-guard edge. A single-cycle high glitch does not end the wait.
- R5: Each byte holds read-enable low for cyc+1 cycles and then high for one cycle. The byte on the data bus is captured at the edge where read-enable returns high. The data-valid output is high for exactly that one cycle and carries the captured byte.
- R6: For types 3 and 4, read-enable stays high until the ready wait has ended, and then exactly readLen bytes are read. Type 5 starts reading in the cycle right after acceptance.
- R7: Done is a one-cycle pulse. It follows the gap cycle of the last byte for reads. It comes at the end of the ready wait for types 1 and 2, and for any read type with readLen = 0, which performs no read.
- R8: Busy is high from the cycle after acceptance until the done cycle, and it is low in the done cycle. A command pulse that arrives while busy changes nothing.
- R9: The cycle field, the timing flag and the read length are latched at acceptance. Changing them afterwards has no effect on the running command.
- R10: A synchronous active-high reset returns the block to idle: read-enable high, and busy, done, data-valid and the data output all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | One-cycle command issue pulse |
| cmdType | input | 3 | Command type code (see R1) |
| relaxTiming | input | 1 | Doubles the guard interval when high |
| cycField | input | 4 | Cycle field for guard length and read-enable low time |
| readLen | input | 8 | Number of bytes to read for read types |
| rbPin | input | 1 | Device ready/busy line, low = busy |
| dataIn | input | 8 | Data bus from the device |
| readEnN | output | 1 | Active-low read-enable strobe |
| dataOut | output | 8 | Last captured byte |
| dataValid | output | 1 | One-cycle strobe marking a new byte on dataOut |
| busy | output | 1 | High while a command is in progress |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
Cycle counts are taken from the accepting edge E0. For a wait type, the continuation point B is the first edge at or after D+2 where this edge's ready sample and the previous one were both high. For type 5, B is 0. Relative to B, read-enable is low for cyc+1 cycles of each (cyc+2)-cycle byte slot. The data-valid strobe and the captured byte come at offset cyc+1 within the slot, and done comes at B+readLen*(cyc+2), or at B itself when there is no read. The bench computes each of these edges from the vector's own fields. It drives inputs and samples outputs on the falling edge, so the sample taken after edge k shows exactly what that edge produced. It compares every output on every cycle from E0 up to two cycles past done.

// File: rtl/nand_rb_pkg.sv
package nand_rb_pkg;

  localparam int TYPE_W = 3;

  localparam logic [TYPE_W-1:0] CMD_WR_WAIT_A = 3'd1;
  localparam logic [TYPE_W-1:0] CMD_WR_WAIT_B = 3'd2;
  localparam logic [TYPE_W-1:0] CMD_RD_WAIT_A = 3'd3;
  localparam logic [TYPE_W-1:0] CMD_RD_WAIT_B = 3'd4;
  localparam logic [TYPE_W-1:0] CMD_RD_NOW    = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic loadGuard;
    logic decGuard;
    logic clearFilter;
    logic sampleRb;
    logic loadWait;
    logic decWait;
    logic capture;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic guardZero;
    logic waitZero;
    logic bytesZero;
    logic rbReady;
  } seqStatus_t;

  function automatic logic typeWatched(input logic [TYPE_W-1:0] t);
    return (t == CMD_WR_WAIT_A) || (t == CMD_WR_WAIT_B) ||
           (t == CMD_RD_WAIT_A) || (t == CMD_RD_WAIT_B);
  endfunction

  function automatic logic typeReadAfterWait(input logic [TYPE_W-1:0] t);
    return (t == CMD_RD_WAIT_A) || (t == CMD_RD_WAIT_B);
  endfunction

endpackage

// File: rtl/nand_rb_datapath.sv
module nand_rb_datapath
  import nand_rb_pkg::*;
#(
  parameter int SCY_W  = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic              relaxTiming,
  input  logic [SCY_W-1:0]  cycField,
  input  logic [LEN_W-1:0]  readLen,
  input  logic              rbPin,
  input  logic [DATA_W-1:0] dataIn,
  output seqStatus_t        stat,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  localparam int MAX_CYC   = (1 << SCY_W) - 1;
  localparam int MAX_GUARD = 16 * (2 + MAX_CYC);
  localparam int GUARD_W   = $clog2(MAX_GUARD + 1);

  logic [GUARD_W-1:0] guardCnt;
  logic [GUARD_W-1:0] guardBase;
  logic [GUARD_W-1:0] guardLoad;
  logic [SCY_W-1:0]   waitCnt;
  logic [SCY_W-1:0]   cycHeld;
  logic [SCY_W-1:0]   cycSel;
  logic [LEN_W-1:0]   byteCnt;
  logic               rbPrev;

  // guard length minus one, from the live inputs at acceptance
  always_comb begin
    guardBase = GUARD_W'(cycField) + GUARD_W'(2);
    if (relaxTiming) begin
      guardLoad = (guardBase << 4) - GUARD_W'(1);
    end else begin
      guardLoad = (guardBase << 3) - GUARD_W'(1);
    end
  end

  // at acceptance the register is not yet written, so take the input
  assign cycSel = strb.latchCfg ? cycField : cycHeld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycHeld <= '0;
    end else if (strb.latchCfg) begin
      cycHeld <= cycField;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      guardCnt <= '0;
    end else if (strb.loadGuard) begin
      guardCnt <= guardLoad;
    end else if (strb.decGuard) begin
      guardCnt <= guardCnt - GUARD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt <= '0;
    end else if (strb.loadWait) begin
      waitCnt <= cycSel;
    end else if (strb.decWait) begin
      waitCnt <= waitCnt - SCY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
    end else if (strb.latchCfg) begin
      byteCnt <= readLen;
    end else if (strb.capture) begin
      byteCnt <= byteCnt - LEN_W'(1);
    end
  end

  // two-sample ready filter
  always_ff @(posedge clk) begin
    if (rst) begin
      rbPrev <= 1'b0;
    end else if (strb.clearFilter) begin
      rbPrev <= 1'b0;
    end else if (strb.sampleRb) begin
      rbPrev <= rbPin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strb.capture;
      if (strb.capture) begin
        dataOut <= dataIn;
      end
    end
  end

  always_comb begin
    stat.guardZero = (guardCnt == '0);
    stat.waitZero  = (waitCnt == '0);
    stat.bytesZero = (byteCnt == '0);
    stat.rbReady   = rbPrev & rbPin;
  end

endmodule

// File: rtl/nand_rb_ctrl.sv
module nand_rb_ctrl
  import nand_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [TYPE_W-1:0] cmdType,
  input  logic              lenNonZero,
  input  seqStatus_t        stat,
  output seqStrobe_t        strb,
  output logic              busy,
  output logic              done,
  output logic              readEnN
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_GUARD,
    S_RBWAIT,
    S_RDLOW,
    S_RDGAP
  } seqState_t;

  seqState_t state, stateNext;
  logic      wantRead, wantReadNext;
  logic      doneNext;

  always_comb begin
    stateNext    = state;
    wantReadNext = wantRead;
    doneNext     = 1'b0;
    strb         = '0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          strb.latchCfg = 1'b1;
          wantReadNext  = typeReadAfterWait(cmdType) && lenNonZero;
          if (typeWatched(cmdType)) begin
            strb.loadGuard = 1'b1;
            stateNext      = S_GUARD;
          end else if ((cmdType == CMD_RD_NOW) && lenNonZero) begin
            strb.loadWait = 1'b1;
            stateNext     = S_RDLOW;
          end else begin
            doneNext = 1'b1;
          end
        end
      end
      S_GUARD: begin
        if (stat.guardZero) begin
          strb.clearFilter = 1'b1;
          stateNext        = S_RBWAIT;
        end else begin
          strb.decGuard = 1'b1;
        end
      end
      S_RBWAIT: begin
        strb.sampleRb = 1'b1;
        if (stat.rbReady) begin
          if (wantRead) begin
            strb.loadWait = 1'b1;
            stateNext     = S_RDLOW;
          end else begin
            doneNext  = 1'b1;
            stateNext = S_IDLE;
          end
        end
      end
      S_RDLOW: begin
        if (stat.waitZero) begin
          strb.capture = 1'b1;
          stateNext    = S_RDGAP;
        end else begin
          strb.decWait = 1'b1;
        end
      end
      S_RDGAP: begin
        if (stat.bytesZero) begin
          doneNext  = 1'b1;
          stateNext = S_IDLE;
        end else begin
          strb.loadWait = 1'b1;
          stateNext     = S_RDLOW;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      wantRead <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= stateNext;
      wantRead <= wantReadNext;
      done     <= doneNext;
    end
  end

  assign busy    = (state != S_IDLE);
  assign readEnN = (state != S_RDLOW);

endmodule

// File: rtl/nand_rb_sequencer.sv
module nand_rb_sequencer
  import nand_rb_pkg::*;
#(
  parameter int SCY_W  = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdType,
  input  logic              relaxTiming,
  input  logic [SCY_W-1:0]  cycField,
  input  logic [LEN_W-1:0]  readLen,
  input  logic              rbPin,
  input  logic [DATA_W-1:0] dataIn,
  output logic              readEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strb;
  seqStatus_t stat;

  nand_rb_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdValid   (cmdValid),
    .cmdType    (cmdType),
    .lenNonZero (|readLen),
    .stat       (stat),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .readEnN    (readEnN)
  );

  nand_rb_datapath #(
    .SCY_W  (SCY_W),
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .relaxTiming (relaxTiming),
    .cycField    (cycField),
    .readLen     (readLen),
    .rbPin       (rbPin),
    .dataIn      (dataIn),
    .stat        (stat),
    .dataOut     (dataOut),
    .dataValid   (dataValid)
  );

endmodule

// File: rtl/nand_rb_checker.sv
module nand_rb_checker (
  input logic clk,
  input logic rst,
  input logic readEnN,
  input logic dataValid,
  input logic busy,
  input logic done
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done); // R8

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(readEnN) && !$past(rst)) |-> dataValid); // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid); // R5

  AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !readEnN |-> busy); // R6

endmodule

bind nand_rb_sequencer nand_rb_checker i_checker (
  .clk       (clk),
  .rst       (rst),
  .readEnN   (readEnN),
  .dataValid (dataValid),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_nand_rb_sequencer.sv
module test_nand_rb_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [15:0] NONE = 16'hFFFF;

  typedef struct packed {
    logic [2:0]  ty;
    logic        relax;
    logic [3:0]  cyc;
    logic [7:0]  len;
    logic [15:0] lowFrom;
    logic [15:0] lowUntil;
    logic [15:0] glitch;
    logic [15:0] intrAt;
    logic [7:0]  seed;
  } vec_t;

  // ty relax cyc len lowFrom lowUntil glitch intrAt seed
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 1'b0, 4'd0,  8'd0, 16'd0, 16'd40,  NONE,   16'd0,  8'h00},
    '{3'd2, 1'b1, 4'd1,  8'd0, 16'd0, 16'd0,   NONE,   16'd10, 8'h00},
    '{3'd3, 1'b0, 4'd2,  8'd3, 16'd2, 16'd60,  16'd45, 16'd0,  8'h10},
    '{3'd4, 1'b1, 4'd3,  8'd2, 16'd5, 16'd100, NONE,   16'd20, 8'hA0},
    '{3'd5, 1'b0, 4'd0,  8'd4, 16'd0, 16'd0,   NONE,   16'd0,  8'h33},
    '{3'd5, 1'b0, 4'd15, 8'd1, 16'd0, 16'd0,   NONE,   16'd3,  8'h5C},
    '{3'd0, 1'b0, 4'd2,  8'd5, 16'd0, 16'd0,   NONE,   16'd0,  8'h00},
    '{3'd7, 1'b1, 4'd4,  8'd2, 16'd0, 16'd0,   NONE,   16'd0,  8'h00},
    '{3'd3, 1'b0, 4'd15, 8'd0, 16'd0, 16'd0,   NONE,   16'd0,  8'h00},
    '{3'd1, 1'b1, 4'd15, 8'd0, 16'd3, 16'd250, NONE,   16'd0,  8'h00},
    '{3'd6, 1'b1, 4'd1,  8'd3, 16'd0, 16'd0,   NONE,   16'd0,  8'h00},
    '{3'd5, 1'b0, 4'd1,  8'd0, 16'd0, 16'd0,   NONE,   16'd0,  8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdType = '0;
  logic       relaxTiming = 1'b0;
  logic [3:0] cycField = '0;
  logic [7:0] readLen = '0;
  logic       rbPin = 1'b1;
  logic [7:0] dataIn = '0;
  logic       readEnN;
  logic [7:0] dataOut;
  logic       dataValid;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_rb_sequencer i_nand_rb_sequencer (
    .clk         (clk),
    .rst         (rst),
    .cmdValid    (cmdValid),
    .cmdType     (cmdType),
    .relaxTiming (relaxTiming),
    .cycField    (cycField),
    .readLen     (readLen),
    .rbPin       (rbPin),
    .dataIn      (dataIn),
    .readEnN     (readEnN),
    .dataOut     (dataOut),
    .dataValid   (dataValid),
    .busy        (busy),
    .done        (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // rbPin level driven at the sample point after edge o
  function automatic bit rbHighObs(input vec_t v, input int o);
    return !((o >= int'(v.lowFrom)) && (o < int'(v.lowUntil)) && (o != int'(v.glitch)));
  endfunction

  // sampled level at edge m
  function automatic bit rbHighEdge(input vec_t v, input int m);
    return rbHighObs(v, m - 1);
  endfunction

  task automatic checkIdle(input string tag);
    check(readEnN === 1'b1, {tag, " readEnN"}, int'(readEnN), 1);
    check(busy === 1'b0, {tag, " busy"}, int'(busy), 0);
    check(done === 1'b0, {tag, " done"}, int'(done), 0);
    check(dataValid === 1'b0, {tag, " dataValid"}, int'(dataValid), 0);
  endtask

  task automatic runVec(input int idx);
    vec_t v;
    int d, b, p, dn, j;
    bit watched, doRead;
    string tag;
    v = VECS[idx];
    tag = $sformatf("vec%0d", idx);
    d = (v.relax ? 16 : 8) * (2 + int'(v.cyc));
    p = int'(v.cyc) + 2;
    watched = (v.ty >= 3'd1) && (v.ty <= 3'd4);
    doRead = ((v.ty == 3'd3) || (v.ty == 3'd4) || (v.ty == 3'd5)) && (v.len != 0);
    b = 0;
    if (watched) begin
      j = d + 2;
      while (!(rbHighEdge(v, j) && rbHighEdge(v, j - 1))) j++;
      b = j;
    end
    dn = doRead ? b + int'(v.len) * p : b;

    @(negedge clk);
    cmdType = v.ty;
    relaxTiming = v.relax;
    cycField = v.cyc;
    readLen = v.len;
    cmdValid = 1'b1;
    dataIn = v.seed;
    rbPin = rbHighObs(v, -1);

    for (int k = 0; k <= dn + 2; k++) begin
      bit inSlot, expLow, expDv;
      int ofs;
      @(negedge clk);
      if (k == 0) begin
        // R9: changed settings after acceptance must not matter
        cycField = ~v.cyc;
        relaxTiming = ~v.relax;
        readLen = ~v.len;
      end
      ofs = k - b;
      inSlot = doRead && (k >= b) && (ofs / p < int'(v.len));
      expLow = inSlot && (ofs % p <= int'(v.cyc));
      expDv = inSlot && (ofs % p == int'(v.cyc) + 1);
      // R2 R3 R4 R6: read-enable timing including hold-off until ready
      check(readEnN === !expLow, $sformatf("R5/R6 %s k=%0d readEnN", tag, k),
            int'(readEnN), int'(!expLow));
      check(dataValid === expDv, $sformatf("R5 %s k=%0d dataValid", tag, k),
            int'(dataValid), int'(expDv));
      if (expDv) begin
        check(dataOut === 8'(int'(v.seed) + k), $sformatf("R5 %s k=%0d dataOut", tag, k),
              int'(dataOut), (int'(v.seed) + k) % 256);
      end
      // R1 R2 R3 R4 R7: completion edge
      check(done === (k == dn), $sformatf("R7 %s k=%0d done", tag, k),
            int'(done), int'(k == dn));
      // R8: busy window, intrusions ignored
      check(busy === (k < dn), $sformatf("R8 %s k=%0d busy", tag, k),
            int'(busy), int'(k < dn));
      cmdValid = (v.intrAt != 0) && (k == int'(v.intrAt));
      cmdType = 3'd5;
      rbPin = rbHighObs(v, k);
      dataIn = 8'(int'(v.seed) + k + 1);
    end
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    checkIdle("R10 reset");
    check(dataOut === 8'h00, "R10 reset dataOut", int'(dataOut), 0);
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R10 after release");

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: vector table
    for (int i = 0; i < NVEC; i++) runVec(i);

    // R10: reset in the middle of a read
    @(negedge clk);
    cmdType = 3'd5;
    cycField = 4'd15;
    readLen = 8'd3;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(readEnN === 1'b0, "R10 pre-reset readEnN", int'(readEnN), 0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R10 mid-read reset");
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(done === 1'b0 && readEnN === 1'b1, "R10 no resume after reset",
          int'(done), 0);

    // block works normally after reset
    runVec(4);
    runVec(2);

    finishRun();
  end

endmodule